// File: doc/BRIEF.md
# Write-Through Parity-Protected Level-One Data Cache

This block is a small first-level data cache that sits between a core's load/store port and the next cache level. Loads that hit return a word from a two-way set-associative array. Loads that miss fetch a whole line from below, one word per beat. Every store is passed straight down on a dedicated write-through output. When the store address is already resident, the store also updates the local copy in the same cycle.

Because the level below always holds a correct copy of every resident line, the array carries only one even-parity bit per data byte and no correcting code. A store writes the enabled bytes and their parity bits directly from the new data, without reading the old word. When a load finds a parity mismatch, the line is invalidated and fetched again. The core then receives the refetched word as if the access had been an ordinary miss. Replacing a valid line produces no traffic at all, since nothing held locally is newer than the copy below. A test input lets a store deliberately write inverted parity, so that the recovery path can be exercised from the ports.

Top module: `wtdc_top`

## Requirements
- R1: A load that hits a valid line with good parity asserts `cpu_rsp_valid` with the addressed 64-bit word in the cycle right after the request is accepted (`cpu_valid` and `cpu_ready` both high at a rising edge).
- R2: A load miss issues exactly one line read on `fill_req_addr`, aligned to 64 bytes (offset bits [5:0] zero). The line returns as eight beats in ascending word order (beat k is bytes 8k..8k+7). The core receives the requested word one cycle after the last beat, and that word is the next level's current content.
- R3: Every accepted store drives `wt_valid` in the cycle after acceptance, carrying the request's address, data and byte enables. On a hit, only the bytes whose `cpu_be` bit is set (bit b selects bits 8b+7..8b) change in the local copy, in that same cycle.
- R4: A store that misses does not allocate a line. It appears only on the write-through port, and a later load to that address misses.
- R5: A refill that replaces a valid line produces no write-through or other traffic toward the next level. It takes the same number of cycles as a refill into an empty way.
- R6: Each data byte has one even-parity bit. A store recomputes parity only for its enabled bytes, from the new bytes alone. A store with `cpu_par_flip` high writes the inverse of that parity for its enabled bytes, and leaves other bytes and words of the line intact.
- R7: A load that finds a parity mismatch in the addressed word invalidates the line, refetches it from the next level, and returns the refetched (correct) word. A repeat load then hits.
- R8: Out of reset `cpu_ready` is high and `cpu_rsp_valid`, `wt_valid` and `fill_req_valid` are low. After each accepted request `cpu_ready` stays low until that request completes, so at most one miss or refetch is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Core request present |
| cpu_ready | output | 1 | Cache accepts a request this cycle |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address; bits [2:0] ignored |
| cpu_wdata | input | DATA_W | Store data |
| cpu_be | input | DATA_W/8 | Store byte enables |
| cpu_par_flip | input | 1 | Test: store writes inverted parity on its enabled bytes |
| cpu_rsp_valid | output | 1 | Load data valid |
| cpu_rsp_data | output | DATA_W | Load data |
| fill_req_valid | output | 1 | Line read request to next level |
| fill_req_ready | input | 1 | Next level takes the line read |
| fill_req_addr | output | ADDR_W | Line-aligned read address |
| fill_beat_valid | input | 1 | Refill beat present |
| fill_beat_data | input | DATA_W | Refill beat data, ascending word order |
| wt_valid | output | 1 | Write-through store present |
| wt_addr | output | ADDR_W | Store address |
| wt_data | output | DATA_W | Store data |
| wt_be | output | DATA_W/8 | Store byte enables |

## Verification
After the acceptance edge, a load hit and the write-through of a store are both due in the next cycle. A miss or a refetch response is due one cycle after the eighth refill beat. The bench drives on the falling edge and counts falling edges after the acceptance edge. A hit must show its response at the first falling edge, and a store must show its forwarded fields there too. Refill latencies are measured in the same way, and the measurement for an evicting refill is compared with the measurement for a refill into an empty way.

// File: rtl/wtdc_pkg.sv
package wtdc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOOK  = 3'd1,
    ST_RDREQ = 3'd2,
    ST_FILL  = 3'd3,
    ST_RESP  = 3'd4
  } wtdc_state_e;

  // even parity over one byte
  function automatic logic byte_parity(input logic [7:0] b);
    return ^b;
  endfunction

endpackage

// File: rtl/wtdc_tags.sv
module wtdc_tags #(
  parameter int SETS  = 16,
  parameter int WAYS  = 2,
  parameter int TAG_W = 22,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SET_W-1:0]           rd_set,
  output logic [WAYS-1:0][TAG_W-1:0] rd_tag,
  output logic [WAYS-1:0]            rd_val,
  input  logic                       tag_we,
  input  logic [SET_W-1:0]           wr_set,
  input  logic [WAY_W-1:0]           wr_way,
  input  logic [TAG_W-1:0]           wr_tag,
  input  logic                       val_clr,
  input  logic                       val_set
);

  logic [TAG_W-1:0] tag_mem [SETS][WAYS];
  logic [WAYS-1:0]  val_q   [SETS];
  logic [WAYS-1:0]  val_d   [SETS];

  always_comb begin
    val_d = val_q;
    if (val_clr) val_d[wr_set][wr_way] = 1'b0;
    if (val_set) val_d[wr_set][wr_way] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) val_q[s] <= '0;
    end else begin
      val_q <= val_d;
    end
  end

  always_ff @(posedge clk) begin
    if (tag_we) tag_mem[wr_set][wr_way] <= wr_tag;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_tag[w] = tag_mem[rd_set][w];
    assign rd_val[w] = val_q[rd_set][w];
  end

endmodule

// File: rtl/wtdc_data.sv
module wtdc_data
  import wtdc_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int WAYS   = 2,
  parameter int WORDS  = 8,
  parameter int WBYTES = 8,
  localparam int DATA_W = WBYTES * 8,
  localparam int SET_W  = $clog2(SETS),
  localparam int WIDX_W = $clog2(WORDS),
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                        clk,
  input  logic [SET_W-1:0]            rd_set,
  input  logic [WIDX_W-1:0]           rd_word,
  output logic [WAYS-1:0][DATA_W-1:0] rd_data,
  output logic [WAYS-1:0][WBYTES-1:0] rd_par,
  input  logic                        wr_en,
  input  logic [SET_W-1:0]            wr_set,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [WIDX_W-1:0]           wr_word,
  input  logic [WBYTES-1:0]           wr_be,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        wr_par_inv
);

  logic [DATA_W-1:0] dat_mem [SETS][WAYS][WORDS];
  logic [WBYTES-1:0] par_mem [SETS][WAYS][WORDS];

  // byte-granular write: data and parity come only from the new bytes
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < WBYTES; b++) begin
        if (wr_be[b]) begin
          dat_mem[wr_set][wr_way][wr_word][b*8 +: 8] <= wr_data[b*8 +: 8];
          par_mem[wr_set][wr_way][wr_word][b] <= byte_parity(wr_data[b*8 +: 8]) ^ wr_par_inv;
        end
      end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_data[w] = dat_mem[rd_set][w][rd_word];
    assign rd_par[w]  = par_mem[rd_set][w][rd_word];
  end

endmodule

// File: rtl/wtdc_lookup.sv
module wtdc_lookup
  import wtdc_pkg::*;
#(
  parameter int WAYS   = 2,
  parameter int TAG_W  = 22,
  parameter int WBYTES = 8,
  localparam int DATA_W = WBYTES * 8,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
  input  logic [WAYS-1:0]             rd_val,
  input  logic [WAYS-1:0][DATA_W-1:0] rd_data,
  input  logic [WAYS-1:0][WBYTES-1:0] rd_par,
  input  logic [TAG_W-1:0]            req_tag,
  output logic [WAYS-1:0]             hit_vec,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way,
  output logic [DATA_W-1:0]           hit_data,
  output logic                        par_err
);

  logic [WAYS-1:0][WBYTES-1:0] bad;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_vec[w] = rd_val[w] && (rd_tag[w] == req_tag);
    for (genvar b = 0; b < WBYTES; b++) begin : g_byte
      assign bad[w][b] = rd_par[w][b] != byte_parity(rd_data[w][b*8 +: 8]);
    end
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way  = '0;
    hit_data = '0;
    par_err  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        hit_way  = WAY_W'(w);
        hit_data = rd_data[w];
        par_err  = |bad[w];
      end
    end
  end

endmodule

// File: rtl/wtdc_victim.sv
module wtdc_victim #(
  parameter int WAYS = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [WAYS-1:0]  set_val,
  output logic [WAY_W-1:0] victim_way
);

  logic [7:0] lfsr_q;
  logic [7:0] lfsr_d;

  always_comb begin
    lfsr_d = lfsr_q;
    if (step) lfsr_d = {lfsr_q[6:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= 8'h01;
    else        lfsr_q <= lfsr_d;
  end

  // an empty way wins; otherwise the pseudo-random pick
  always_comb begin
    victim_way = lfsr_q[WAY_W-1:0];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!set_val[w]) victim_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/wtdc_top.sv
module wtdc_top
  import wtdc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 16,
  parameter int WAYS       = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_valid,
  output logic                cpu_ready,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic [DATA_W/8-1:0] cpu_be,
  input  logic                cpu_par_flip,
  output logic                cpu_rsp_valid,
  output logic [DATA_W-1:0]   cpu_rsp_data,
  output logic                fill_req_valid,
  input  logic                fill_req_ready,
  output logic [ADDR_W-1:0]   fill_req_addr,
  input  logic                fill_beat_valid,
  input  logic [DATA_W-1:0]   fill_beat_data,
  output logic                wt_valid,
  output logic [ADDR_W-1:0]   wt_addr,
  output logic [DATA_W-1:0]   wt_data,
  output logic [DATA_W/8-1:0] wt_be
);

  localparam int WBYTES = DATA_W / 8;
  localparam int WORDS  = LINE_BYTES / WBYTES;
  localparam int WB_W   = $clog2(WBYTES);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WIDX_W = $clog2(WORDS);
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

  wtdc_state_e st_q, st_d;

  logic                req_we_q;
  logic [ADDR_W-1:0]   req_addr_q;
  logic [DATA_W-1:0]   req_wdata_q;
  logic [WBYTES-1:0]   req_be_q;
  logic                req_flip_q;
  logic [WIDX_W-1:0]   beat_q, beat_d;
  logic [WAY_W-1:0]    fill_way_q, fill_way_d;
  logic [DATA_W-1:0]   rsp_q, rsp_d;

  logic                accept;
  logic [SET_W-1:0]    req_set;
  logic [WIDX_W-1:0]   req_word;
  logic [TAG_W-1:0]    req_tag;

  logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
  logic [WAYS-1:0]             rd_val;
  logic [WAYS-1:0][DATA_W-1:0] rd_data;
  logic [WAYS-1:0][WBYTES-1:0] rd_par;
  logic [WAYS-1:0]             hit_vec;
  logic                        hit;
  logic [WAY_W-1:0]            hit_way;
  logic [DATA_W-1:0]           hit_data;
  logic                        par_err;
  logic [WAY_W-1:0]            victim_way;

  logic                tag_we, val_clr, val_set;
  logic [WAY_W-1:0]    tag_way;
  logic                d_we;
  logic [WAY_W-1:0]    d_way;
  logic [WIDX_W-1:0]   d_word;
  logic [WBYTES-1:0]   d_be;
  logic [DATA_W-1:0]   d_data;
  logic                d_inv;

  assign cpu_ready = (st_q == ST_IDLE);
  assign accept    = cpu_valid && cpu_ready;
  assign req_word  = req_addr_q[OFF_W-1:WB_W];
  assign req_set   = req_addr_q[OFF_W+SET_W-1:OFF_W];
  assign req_tag   = req_addr_q[ADDR_W-1:OFF_W+SET_W];

  assign wt_addr       = req_addr_q;
  assign wt_data       = req_wdata_q;
  assign wt_be         = req_be_q;
  assign fill_req_addr = {req_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  wtdc_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_set  (req_set),
    .rd_tag  (rd_tag),
    .rd_val  (rd_val),
    .tag_we  (tag_we),
    .wr_set  (req_set),
    .wr_way  (tag_way),
    .wr_tag  (req_tag),
    .val_clr (val_clr),
    .val_set (val_set)
  );

  wtdc_data #(.SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .WBYTES(WBYTES)) u_data (
    .clk        (clk),
    .rd_set     (req_set),
    .rd_word    (req_word),
    .rd_data    (rd_data),
    .rd_par     (rd_par),
    .wr_en      (d_we),
    .wr_set     (req_set),
    .wr_way     (d_way),
    .wr_word    (d_word),
    .wr_be      (d_be),
    .wr_data    (d_data),
    .wr_par_inv (d_inv)
  );

  wtdc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .WBYTES(WBYTES)) u_lookup (
    .rd_tag   (rd_tag),
    .rd_val   (rd_val),
    .rd_data  (rd_data),
    .rd_par   (rd_par),
    .req_tag  (req_tag),
    .hit_vec  (hit_vec),
    .hit      (hit),
    .hit_way  (hit_way),
    .hit_data (hit_data),
    .par_err  (par_err)
  );

  wtdc_victim #(.WAYS(WAYS)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (accept),
    .set_val    (rd_val),
    .victim_way (victim_way)
  );

  // next-state and datapath control
  always_comb begin
    st_d          = st_q;
    beat_d        = beat_q;
    fill_way_d    = fill_way_q;
    rsp_d         = rsp_q;
    cpu_rsp_valid = 1'b0;
    cpu_rsp_data  = rsp_q;
    wt_valid      = 1'b0;
    fill_req_valid = 1'b0;
    tag_we        = 1'b0;
    val_clr       = 1'b0;
    val_set       = 1'b0;
    tag_way       = fill_way_q;
    d_we          = 1'b0;
    d_way         = hit_way;
    d_word        = req_word;
    d_be          = req_be_q;
    d_data        = req_wdata_q;
    d_inv         = req_flip_q;
    unique case (st_q)
      ST_IDLE: begin
        if (cpu_valid) st_d = ST_LOOK;
      end
      ST_LOOK: begin
        if (req_we_q) begin
          wt_valid = 1'b1;
          d_we     = hit;
          st_d     = ST_IDLE;
        end else if (hit && !par_err) begin
          cpu_rsp_valid = 1'b1;
          cpu_rsp_data  = hit_data;
          st_d          = ST_IDLE;
        end else begin
          // miss, or corrupted line: drop it and refill the chosen way
          fill_way_d = hit ? hit_way : victim_way;
          tag_way    = fill_way_d;
          tag_we     = 1'b1;
          val_clr    = 1'b1;
          st_d       = ST_RDREQ;
        end
      end
      ST_RDREQ: begin
        fill_req_valid = 1'b1;
        if (fill_req_ready) begin
          beat_d = '0;
          st_d   = ST_FILL;
        end
      end
      ST_FILL: begin
        d_way  = fill_way_q;
        d_word = beat_q;
        d_be   = '1;
        d_data = fill_beat_data;
        d_inv  = 1'b0;
        if (fill_beat_valid) begin
          d_we   = 1'b1;
          beat_d = beat_q + 1'b1;
          if (beat_q == req_word) rsp_d = fill_beat_data;
          if (beat_q == WIDX_W'(WORDS - 1)) begin
            val_set = 1'b1;
            st_d    = ST_RESP;
          end
        end
      end
      ST_RESP: begin
        cpu_rsp_valid = 1'b1;
        st_d          = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      beat_q     <= '0;
      fill_way_q <= '0;
    end else begin
      st_q       <= st_d;
      beat_q     <= beat_d;
      fill_way_q <= fill_way_d;
    end
  end

  // request capture, enabled by acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_we_q   <= 1'b0;
      req_addr_q <= '0;
      req_flip_q <= 1'b0;
    end else if (accept) begin
      req_we_q   <= cpu_we;
      req_addr_q <= cpu_addr;
      req_flip_q <= cpu_par_flip;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      req_wdata_q <= cpu_wdata;
      req_be_q    <= cpu_be;
    end
  end

  always_ff @(posedge clk) begin
    rsp_q <= rsp_d;
  end

endmodule

// File: rtl/wtdc_sva.sv
module wtdc_sva #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int WAYS   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rsp_valid,
  input logic              wt_valid,
  input logic [ADDR_W-1:0] wt_addr,
  input logic              fill_req_valid,
  input logic              fill_req_ready,
  input logic [ADDR_W-1:0] fill_req_addr,
  input logic              fill_beat_valid,
  input logic [WAYS-1:0]   hit_vec
);

  a_r3_store_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && cpu_we) |=> (wt_valid && wt_addr == $past(cpu_addr)));

  a_r3_wt_only_from_store: assert property (@(posedge clk) disable iff (!rst_n)
    wt_valid |-> $past(cpu_valid && cpu_ready && cpu_we));

  a_r8_stall_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready) |=> !cpu_ready);

  a_r8_single_miss: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid |-> !cpu_ready);

  a_r1_no_rsp_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !cpu_rsp_valid);

  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && !fill_req_ready) |=> (fill_req_valid && $stable(fill_req_addr)));

  a_r2_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid |-> (fill_req_addr[OFF_W-1:0] == '0));

  a_r2_unique_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r5_silent_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill_beat_valid |-> !wt_valid);

endmodule

bind wtdc_top wtdc_sva #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .WAYS(WAYS)) u_sva (
  .clk             (clk),
  .rst_n           (rst_n),
  .cpu_valid       (cpu_valid),
  .cpu_ready       (cpu_ready),
  .cpu_we          (cpu_we),
  .cpu_addr        (cpu_addr),
  .cpu_rsp_valid   (cpu_rsp_valid),
  .wt_valid        (wt_valid),
  .wt_addr         (wt_addr),
  .fill_req_valid  (fill_req_valid),
  .fill_req_ready  (fill_req_ready),
  .fill_req_addr   (fill_req_addr),
  .fill_beat_valid (fill_beat_valid),
  .hit_vec         (hit_vec)
);

// File: tb/wtdc_top_tb_top.sv
module wtdc_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cpu_valid;
  logic        cpu_ready;
  logic        cpu_we;
  logic [31:0] cpu_addr;
  logic [63:0] cpu_wdata;
  logic [7:0]  cpu_be;
  logic        cpu_par_flip;
  logic        cpu_rsp_valid;
  logic [63:0] cpu_rsp_data;
  logic        fill_req_valid;
  logic        fill_req_ready;
  logic [31:0] fill_req_addr;
  logic        fill_beat_valid;
  logic [63:0] fill_beat_data;
  logic        wt_valid;
  logic [31:0] wt_addr;
  logic [63:0] wt_data;
  logic [7:0]  wt_be;

  wtdc_top dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .cpu_valid       (cpu_valid),
    .cpu_ready       (cpu_ready),
    .cpu_we          (cpu_we),
    .cpu_addr        (cpu_addr),
    .cpu_wdata       (cpu_wdata),
    .cpu_be          (cpu_be),
    .cpu_par_flip    (cpu_par_flip),
    .cpu_rsp_valid   (cpu_rsp_valid),
    .cpu_rsp_data    (cpu_rsp_data),
    .fill_req_valid  (fill_req_valid),
    .fill_req_ready  (fill_req_ready),
    .fill_req_addr   (fill_req_addr),
    .fill_beat_valid (fill_beat_valid),
    .fill_beat_data  (fill_beat_data),
    .wt_valid        (wt_valid),
    .wt_addr         (wt_addr),
    .wt_data         (wt_data),
    .wt_be           (wt_be)
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // next-level memory model: default pattern plus merged write-through stores
  logic [63:0] mem_ovr [logic [28:0]];
  int          rd_cnt = 0;
  int          wt_cnt = 0;
  logic [31:0] last_rd_addr = '0;
  logic [63:0] mrg;

  function automatic logic [63:0] model_rd(input logic [28:0] wa);
    if (mem_ovr.exists(wa)) return mem_ovr[wa];
    return {32'h5A5A_0F0F ^ {3'b0, wa}, ~{3'b0, wa}};
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      if (fill_req_valid && fill_req_ready) begin
        rd_cnt++;
        last_rd_addr = fill_req_addr;
      end
      if (wt_valid) begin
        wt_cnt++;
        mrg = model_rd(wt_addr[31:3]);
        for (int b = 0; b < 8; b++)
          if (wt_be[b]) mrg[b*8 +: 8] = wt_data[b*8 +: 8];
        mem_ovr[wt_addr[31:3]] = mrg;
      end
    end
  end

  // next-level responder: one cycle to accept, two idle, eight beats
  initial begin
    fill_req_ready  = 1'b0;
    fill_beat_valid = 1'b0;
    fill_beat_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && fill_req_valid) begin
        logic [31:0] la;
        la = fill_req_addr;
        fill_req_ready = 1'b1;
        @(negedge clk);
        fill_req_ready = 1'b0;
        repeat (2) @(negedge clk);
        for (int b = 0; b < 8; b++) begin
          fill_beat_valid = 1'b1;
          fill_beat_data  = model_rd(la[31:3] + 29'(b));
          @(negedge clk);
        end
        fill_beat_valid = 1'b0;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one core access; lat counts falling edges from acceptance to response
  task automatic do_op(input logic we, input logic [31:0] a, input logic [63:0] wd,
                       input logic [7:0] be, input logic flip,
                       output logic [63:0] rd, output int lat, output logic missed,
                       output logic stall_ok, output logic wt_ok);
    int rd0;
    int n;
    rd0 = rd_cnt;
    n   = 0;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be; cpu_par_flip = flip;
    #1;
    while (!cpu_ready && n < 1000) begin
      @(negedge clk); #1; n++;
    end
    @(posedge clk);
    @(negedge clk);
    cpu_valid = 1'b0; cpu_par_flip = 1'b0;
    lat = 1; stall_ok = 1'b1; rd = '0;
    wt_ok = wt_valid && (wt_addr == a) && (wt_data == wd) && (wt_be == be);
    if (!we) begin
      while (!cpu_rsp_valid && lat < 300) begin
        if (cpu_ready) stall_ok = 1'b0;
        @(negedge clk);
        lat++;
      end
      rd = cpu_rsp_data;
    end
    missed = (rd_cnt != rd0);
  endtask

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [63:0] wdata;
    logic [7:0]  be;
    logic        exp_miss;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b0, 32'h0000_1000, 64'h0,                   8'h00, 1'b1},
    '{1'b0, 32'h0000_1008, 64'h0,                   8'h00, 1'b0},
    '{1'b1, 32'h0000_1010, 64'h1122_3344_5566_7788, 8'h0F, 1'b0},
    '{1'b0, 32'h0000_1010, 64'h0,                   8'h00, 1'b0},
    '{1'b1, 32'h0000_2040, 64'hCAFE_F00D_0BAD_BEEF, 8'hFF, 1'b1},
    '{1'b0, 32'h0000_2040, 64'h0,                   8'h00, 1'b1},
    '{1'b0, 32'h0000_1038, 64'h0,                   8'h00, 1'b0},
    '{1'b1, 32'h0000_2048, 64'hA1B2_C3D4_E5F6_0718, 8'h81, 1'b0},
    '{1'b0, 32'h0000_2048, 64'h0,                   8'h00, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd;
    int          lat, la_lat, lc_lat;
    logic        missed, stall_ok, wt_ok;
    int          rd0, wt0;

    rst_n = 1'b0; cpu_valid = 1'b0; cpu_we = 1'b0; cpu_addr = '0;
    cpu_wdata = '0; cpu_be = '0; cpu_par_flip = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: reset state
    chk(cpu_ready === 1'b1, "R8 ready after reset", 64'(cpu_ready), 64'd1);
    chk(cpu_rsp_valid === 1'b0 && wt_valid === 1'b0 && fill_req_valid === 1'b0,
        "R8 outputs idle after reset", {61'd0, cpu_rsp_valid, wt_valid, fill_req_valid}, 64'd0);

    // vector table walk
    for (int i = 0; i < 9; i++) begin
      vec_t v;
      v = VECS[i];
      do_op(v.we, v.addr, v.wdata, v.be, 1'b0, rd, lat, missed, stall_ok, wt_ok);
      if (v.we) begin
        chk(wt_ok, "R3 store forwarded next cycle", 64'(wt_ok), 64'd1);
        chk(!missed, v.exp_miss ? "R4 store miss reads nothing" : "R3 store hit reads nothing",
            64'(missed), 64'd0);
      end else begin
        chk(rd == model_rd(v.addr[31:3]), v.exp_miss ? "R2 miss data" : "R1 hit data",
            rd, model_rd(v.addr[31:3]));
        chk(missed == v.exp_miss, v.exp_miss ? "R2/R4 load missed" : "R1 load hit",
            64'(missed), 64'(v.exp_miss));
        if (v.exp_miss) begin
          chk(last_rd_addr == (v.addr & 32'hFFFF_FFC0), "R2 line-aligned read",
              64'(last_rd_addr), 64'(v.addr & 32'hFFFF_FFC0));
          chk(stall_ok, "R8 ready low during miss", 64'(stall_ok), 64'd1);
        end else begin
          chk(lat == 1, "R1 hit latency", 64'(lat), 64'd1);
        end
      end
    end

    // R5: evicting refill is silent and no slower
    do_op(1'b0, 32'h0000_0080, '0, '0, 1'b0, rd, la_lat, missed, stall_ok, wt_ok);
    do_op(1'b0, 32'h0000_0480, '0, '0, 1'b0, rd, lat, missed, stall_ok, wt_ok);
    wt0 = wt_cnt;
    do_op(1'b0, 32'h0000_0880, '0, '0, 1'b0, rd, lc_lat, missed, stall_ok, wt_ok);
    chk(missed, "R5 third tag misses", 64'(missed), 64'd1);
    chk(wt_cnt == wt0, "R5 eviction silent", 64'(wt_cnt - wt0), 64'd0);
    chk(lc_lat == la_lat, "R5 eviction adds no cycles", 64'(lc_lat), 64'(la_lat));
    chk(rd == model_rd(29'h0000_0880 >> 3), "R5 evicting fill data", rd, model_rd(29'h0000_0880 >> 3));
    rd0 = rd_cnt;
    do_op(1'b0, 32'h0000_0880, '0, '0, 1'b0, rd, lat, missed, stall_ok, wt_ok);
    chk(!missed && lat == 1, "R5 new line resident", 64'(lat), 64'd1);
    do_op(1'b0, 32'h0000_0080, '0, '0, 1'b0, rd, lat, missed, stall_ok, wt_ok);
    chk(rd == model_rd(29'h0000_0080 >> 3), "R5 reload A data", rd, model_rd(29'h0000_0080 >> 3));
    do_op(1'b0, 32'h0000_0480, '0, '0, 1'b0, rd, lat, missed, stall_ok, wt_ok);
    chk(rd == model_rd(29'h0000_0480 >> 3), "R5 reload B data", rd, model_rd(29'h0000_0480 >> 3));
    chk(rd_cnt - rd0 >= 1, "R5 one of A/B was evicted", 64'(rd_cnt - rd0), 64'd1);

    // R6: flipped parity stays confined to its word and byte
    do_op(1'b1, 32'h0000_1000, 64'h0000_0000_0000_00EE, 8'h01, 1'b1, rd, lat, missed, stall_ok, wt_ok);
    chk(wt_ok, "R6 flip store forwarded", 64'(wt_ok), 64'd1);
    do_op(1'b0, 32'h0000_1008, '0, '0, 1'b0, rd, lat, missed, stall_ok, wt_ok);
    chk(!missed && lat == 1, "R6 neighbour word untouched", 64'(missed), 64'd0);
    do_op(1'b1, 32'h0000_1028, 64'h0000_0055_0000_0000, 8'h10, 1'b1, rd, lat, missed, stall_ok, wt_ok);
    do_op(1'b1, 32'h0000_1028, 64'h0000_0077_0000_0000, 8'h10, 1'b0, rd, lat, missed, stall_ok, wt_ok);
    do_op(1'b0, 32'h0000_1028, '0, '0, 1'b0, rd, lat, missed, stall_ok, wt_ok);
    chk(!missed && lat == 1, "R6 parity rebuilt from new byte", 64'(missed), 64'd0);
    chk(rd == model_rd(29'h0000_1028 >> 3), "R6 merged byte data", rd, model_rd(29'h0000_1028 >> 3));

    // R7: corrupted word refetched
    do_op(1'b0, 32'h0000_1000, '0, '0, 1'b0, rd, lat, missed, stall_ok, wt_ok);
    chk(missed, "R7 parity error refetches", 64'(missed), 64'd1);
    chk(rd == model_rd(29'h0000_1000 >> 3), "R7 refetched data", rd, model_rd(29'h0000_1000 >> 3));
    chk(last_rd_addr == 32'h0000_1000, "R7 refetch address", 64'(last_rd_addr), 64'h1000);
    do_op(1'b0, 32'h0000_1000, '0, '0, 1'b0, rd, lat, missed, stall_ok, wt_ok);
    chk(!missed && lat == 1, "R7 repeat load hits", 64'(lat), 64'd1);
    chk(rd == model_rd(29'h0000_1000 >> 3), "R7 repeat data", rd, model_rd(29'h0000_1000 >> 3));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule